// File: doc/BRIEF.md
# Display Line Latch with Four-Level Drive Select

This block keeps one displayed line of pixel bits for a dot-matrix panel column driver and turns each stored bit into a 2-bit code naming the analog level its output pin should carry. A loader upstream assembles the next line in its own register and presents it on `line_in`. A falling transition of the line strobe `load_strb` commits that whole line to the display register in one step.

The drive code of every output depends on three things: the stored bit, the frame-polarity input `ac_pol`, and the active-low blanking input `blank_n`. The panel is driven with alternating polarity from frame to frame. In one polarity, a lit pixel gets the top select level and a dark pixel gets the upper non-select level. In the other polarity, a lit pixel gets the bottom select level and a dark pixel gets the lower non-select level. When blanking is asserted, every output is forced to the top select level.

Both polarity and blanking act combinationally, so a change on either reaches the codes in the same cycle. The strobe is sampled on `clk` by a two-state watcher:
- `LS_LOW`: the strobe was last seen low.
- `LS_HIGH`: the strobe was last seen high.

The watcher has these transitions:
- `LS_LOW`→`LS_HIGH` when the strobe is seen high.
- `LS_HIGH`→`LS_LOW` when the strobe is seen low. This transition is the commit.
- Otherwise it holds its state.

Top module: `line_drive_latch`

## Requirements
- R1: Reset clears the stored line to all zeros and the watcher to `LS_LOW`. With `ac_pol`=0 and `blank_n`=1 after reset, every code therefore reads 01.
- R2: The commit happens at the first rising `clk` edge that samples `load_strb` low after an edge that sampled it high. At that edge, all bits of `line_in` are copied into the stored line together. The new codes are visible right after that edge.
- R3: At every other edge the stored line holds its value whatever `line_in` does. This covers the strobe staying high, the strobe staying low, and the strobe rising.
- R4: A stored 0 with `ac_pol`=0 and `blank_n`=1 gives code 01 (upper non-select level).
- R5: A stored 1 with `ac_pol`=0 and `blank_n`=1 gives code 00 (top select level).
- R6: A stored 0 with `ac_pol`=1 and `blank_n`=1 gives code 10 (lower non-select level).
- R7: A stored 1 with `ac_pol`=1 and `blank_n`=1 gives code 11 (bottom select level).
- R8: `blank_n`=0 forces every code to 00, whatever the stored bit and `ac_pol`.
- R9: Changes on `ac_pol` and `blank_n` reach the codes combinationally, without a clock edge and without a new commit.
- R10: The code for stored bit i sits at `level_code[2*i+1:2*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | NPIX | Line assembled by the loader |
| load_strb | input | 1 | Line strobe; commit on its high-to-low transition |
| ac_pol | input | 1 | Frame polarity |
| blank_n | input | 1 | Active-low blanking, forces top select level |
| level_code | output | 2*NPIX | Per-output drive level code |

## Verification
A commit is due one edge after the strobe is driven low, following an edge that saw it high. The bench drives inputs on falling clock edges and reads the codes on the next falling edge, so each rising edge has settled before the codes are read. Polarity and blanking have no register in their path, so the bench changes them and samples one nanosecond later, inside the same clock phase, with no edge in between. Hold behaviour is checked by changing `line_in` in each strobe state that must not commit, then reading the codes after the edge that could have altered them.

// File: rtl/line_drive_pkg.sv
package line_drive_pkg;

    typedef enum logic [1:0] {
        LVL_TOP_SEL   = 2'b00,
        LVL_UP_NSEL   = 2'b01,
        LVL_LOW_NSEL  = 2'b10,
        LVL_BOT_SEL   = 2'b11
    } drive_lvl_t;

    typedef enum logic {
        LS_LOW  = 1'b0,
        LS_HIGH = 1'b1
    } strb_state_t;

endpackage

// File: rtl/strobe_watch.sv
module strobe_watch
    import line_drive_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_strb,
    output logic commit
);

    strb_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LS_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            LS_LOW: begin
                if (load_strb) state_d = LS_HIGH;
            end
            LS_HIGH: begin
                if (!load_strb) begin
                    state_d = LS_LOW;
                    commit  = 1'b1;
                end
            end
            default: state_d = LS_LOW;
        endcase
    end

    // R2: a commit is a single edge; the next cycle cannot commit again
    a_r2_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

endmodule

// File: rtl/line_store.sv
module line_store #(
    parameter int NPIX = 160
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic [NPIX-1:0] line_in,
    output logic [NPIX-1:0] stored
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stored <= '0;
        else if (commit) stored <= line_in;
    end

    // R1: first edge out of reset still shows a cleared line
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stored == '0));

    // R2: whole line taken at the commit edge
    a_r2_commit_copy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (stored == $past(line_in)));

    // R3: no commit, no change
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(stored));

endmodule

// File: rtl/level_select.sv
module level_select
    import line_drive_pkg::*;
#(
    parameter int NPIX = 160,
    localparam int CW  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPIX-1:0]    stored,
    input  logic               ac_pol,
    input  logic               blank_n,
    output logic [CW*NPIX-1:0] level_code
);

    logic [NPIX-1:0] hi_bits;

    for (genvar i = 0; i < NPIX; i++) begin : g_pix
        drive_lvl_t lvl;
        always_comb begin
            if (!blank_n) begin
                lvl = LVL_TOP_SEL;
            end else begin
                unique case ({ac_pol, stored[i]})
                    2'b00:   lvl = LVL_UP_NSEL;
                    2'b01:   lvl = LVL_TOP_SEL;
                    2'b10:   lvl = LVL_LOW_NSEL;
                    2'b11:   lvl = LVL_BOT_SEL;
                    default: lvl = LVL_TOP_SEL;
                endcase
            end
        end
        assign level_code[CW*i +: CW] = lvl;
        assign hi_bits[i] = level_code[CW*i+1];
    end

    // R8: blanking forces every code to zero
    a_r8_blank_all_top: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |-> (level_code == '0));

    // R4/R5: low polarity keeps every code in the upper half
    a_r4_low_pol_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && !ac_pol) |-> (hi_bits == '0));

    // R6/R7: high polarity puts every code in the lower half
    a_r6_high_pol_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && ac_pol) |-> (&hi_bits));

endmodule

// File: rtl/line_drive_latch.sv
module line_drive_latch #(
    parameter int NPIX = 160,
    localparam int CW  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPIX-1:0]    line_in,
    input  logic               load_strb,
    input  logic               ac_pol,
    input  logic               blank_n,
    output logic [CW*NPIX-1:0] level_code
);

    logic            commit;
    logic [NPIX-1:0] stored;

    strobe_watch u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_strb (load_strb),
        .commit    (commit)
    );

    line_store #(.NPIX(NPIX)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .line_in (line_in),
        .stored  (stored)
    );

    level_select #(.NPIX(NPIX)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .stored     (stored),
        .ac_pol     (ac_pol),
        .blank_n    (blank_n),
        .level_code (level_code)
    );

endmodule

// File: tb/tb_line_drive_latch.sv
`timescale 1ns/1ps
module tb_line_drive_latch;

    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   line_in = '0;
    logic           load_strb = 1'b0;
    logic           ac_pol = 1'b0;
    logic           blank_n = 1'b1;
    logic [2*N-1:0] level_code;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    line_drive_latch #(.NPIX(N)) dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .load_strb(load_strb),
        .ac_pol(ac_pol), .blank_n(blank_n), .level_code(level_code)
    );

    function automatic logic [2*N-1:0] expect_codes(logic [N-1:0] px, logic p, logic bn);
        logic [2*N-1:0] r;
        for (int i = 0; i < N; i++) begin
            if (!bn)                r[2*i +: 2] = 2'b00;
            else if (!p && !px[i])  r[2*i +: 2] = 2'b01;
            else if (!p &&  px[i])  r[2*i +: 2] = 2'b00;
            else if ( p && !px[i])  r[2*i +: 2] = 2'b10;
            else                    r[2*i +: 2] = 2'b11;
        end
        return r;
    endfunction

    task automatic check(string req, logic [2*N-1:0] exp);
        n_run++;
        if (level_code !== exp) begin
            n_fail++;
            $display("FAIL %s: level_code=%h expected=%h", req, level_code, exp);
        end
    endtask

    task automatic commit_line(logic [N-1:0] v);
        @(negedge clk); load_strb = 1'b1;
        @(negedge clk); load_strb = 1'b0; line_in = v;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: expired before completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] cur;
        line_in = 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset clears line", expect_codes('0, 1'b0, 1'b1));

        // R2/R10: single bit walk checks field position and commit timing
        for (int b = 0; b < N; b++) begin
            commit_line(N'(1) << b);
            check("R10 field position", expect_codes(N'(1) << b, 1'b0, 1'b1));
        end

        // R2: commit not before the low sample
        @(negedge clk); load_strb = 1'b1; line_in = 8'h3C;
        @(negedge clk);
        check("R2 no commit while high", expect_codes(8'h80, 1'b0, 1'b1));
        load_strb = 1'b0;
        @(negedge clk);
        check("R2 commit at falling", expect_codes(8'h3C, 1'b0, 1'b1));
        cur = 8'h3C;

        // R3: low held, line changes
        line_in = 8'hFF;
        @(negedge clk); @(negedge clk);
        check("R3 hold while low", expect_codes(cur, 1'b0, 1'b1));
        // R3: rising edge with new data
        load_strb = 1'b1; line_in = 8'h0F;
        @(negedge clk);
        check("R3 hold on rise", expect_codes(cur, 1'b0, 1'b1));
        line_in = 8'hF0;
        @(negedge clk);
        check("R3 hold while high", expect_codes(cur, 1'b0, 1'b1));
        load_strb = 1'b0; line_in = 8'h5A;
        @(negedge clk);
        check("R2 commit after long high", expect_codes(8'h5A, 1'b0, 1'b1));

        // R4..R8 exhaustive sweep, R9 combinational changes
        for (int v = 0; v < (1 << N); v++) begin
            commit_line(N'(v));
            for (int k = 0; k < 4; k++) begin
                ac_pol  = k[0];
                blank_n = k[1];
                #1;
                if (!k[1])     check("R8 blank forces top", expect_codes(N'(v), k[0], k[1]));
                else if (!k[0]) check("R4 R5 low polarity", expect_codes(N'(v), k[0], k[1]));
                else            check("R6 R7 R9 high polarity", expect_codes(N'(v), k[0], k[1]));
            end
            ac_pol = 1'b0; blank_n = 1'b1;
        end

        // R9: polarity flip without any edge
        @(negedge clk);
        ac_pol = 1'b1; #1;
        check("R9 polarity immediate", expect_codes(8'hFF, 1'b1, 1'b1));
        blank_n = 1'b0; #1;
        check("R9 blank immediate", expect_codes(8'hFF, 1'b1, 1'b0));

        // R1: reset mid-run clears line again
        rst_n = 1'b0; blank_n = 1'b1; ac_pol = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset clears again", expect_codes('0, 1'b1, 1'b1));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule